// File: doc/BRIEF.md
# Scan Chain Instruction-Capture Checker

This block is the host side of a boundary-scan port. It generates the test clock and mode-select line, drives the serial data into the chain and samples the serial data that returns. It is meant to run first, before any other scan operation. A single start strobe makes it force every device on the chain into its reset state. It then steps the chain into the instruction shift state, shifting out the bits each device loaded during the instruction capture step. Finally it returns the chain to the idle state.

The caller supplies the number of devices, the instruction register length of every device and the capture pattern expected from each one. Device 0 is the device nearest the returning data line. Each returned bit is compared against the pattern of the device it belongs to. When the run ends, the block reports pass, or the index of the first device whose bits disagree. A disagreement points to a broken clock, mode or data connection, or to a faulty instruction register path. While the check shifts, it feeds ones into the chain, so every device holds its bypass instruction once the check is over.

Top module: `jtag_chain_check`

## Requirements
- R1: After an accepted start, the mode line is held high for exactly five test-clock rising edges before it is first driven low.
- R2: After the reset edges, the mode line follows 0,1,1,0,0 on the next five rising edges, so the target goes from idle to instruction capture and on into instruction shift with no instruction update before the shift.
- R3: The mode and serial-out lines change only in the system cycle in which the test clock falls, apart from the cycle in which a start is accepted. Returning data is sampled at test-clock rising edges.
- R4: While busy, each high and each low level of the test clock lasts exactly divider+1 system clock cycles. The divider is captured at start.
- R5: The serial-out line is 1 on every shift edge, so each device's instruction register holds all ones after the update.
- R6: The number of shift edges equals the sum of the instruction lengths, and the mode line is 1 only on the last of them. Two further edges with the mode line at 1 and then 0 leave the target in Run-Test/Idle with one instruction update.
- R7: The first returned bit is compared with bit 0 of device 0's expected pattern. Comparison then continues through device 0's higher bits, then device 1, and so on toward the data-in end.
- R8: When every returned bit matches, pass is 1 and the failing-index output holds all ones (7 with default parameters).
- R9: When one or more devices mismatch, pass is 0 and the failing-index output holds the lowest-numbered mismatching device.
- R10: Done is a single-cycle pulse. When done is high, busy and the test clock are low. Pass and the failing index hold their values until the next accepted start.
- R11: After reset, busy, done, pass and the test clock are 0, the mode line is 1 and the failing index is all ones.
- R12: A start strobe while busy is ignored. The run in progress completes with its original configuration and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check when idle |
| num_dev_i | input | IDXW | Devices on the chain, 1..MAX_DEV |
| ir_len_i | input | MAX_DEV*IRLW | Instruction length per device, 2..MAX_IR, device d at bits d*IRLW |
| exp_i | input | MAX_DEV*MAX_IR | Expected capture pattern per device, device d at bits d*MAX_IR, bit 0 returned first |
| div_i | input | DIVW | Test-clock half period minus one, in system cycles |
| tdo_i | input | 1 | Serial data returning from the chain |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Mode select |
| tdi_o | output | 1 | Serial data into the chain |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| pass_o | output | 1 | All devices matched |
| fail_idx_o | output | IDXW | First failing device, all ones on pass |

## Verification
The bench drives a behavioural TAP model that starts in a data-shift state, so a reset phase that is short or missing leaves the model lost and the returned bits garbled. It uses asymmetric capture patterns, so a checker that walks bits or devices in the wrong order reports false failures. Runs with two mismatching devices catch a design that reports the last failure instead of the first. A restart strobe in the middle of a run catches a design that reloads or emits a second done. Level lengths and edge alignment are measured at every divider setting, which exposes an off-by-one divider or a mode line that changes on the rising edge.

// File: rtl/jtag_chk_pkg.sv
package jtag_chk_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_RST, PH_RTI, PH_SDR, PH_SIR, PH_CAP, PH_CAP2,
    PH_SHIFT, PH_UPD, PH_RTI2, PH_FIN
  } phase_e;

  localparam int RESET_EDGES = 5;

  // mode-line level applied on the rising edge that ends a given phase
  function automatic logic tms_for(phase_e ph, logic last_bit);
    case (ph)
      PH_RST, PH_SDR, PH_SIR, PH_UPD: tms_for = 1'b1;
      PH_SHIFT:                       tms_for = last_bit;
      default:                        tms_for = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/jtag_chk_tck.sv
module jtag_chk_tck #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tck,
  output logic            rise_ev,
  output logic            fall_ev
);
  logic [DIVW-1:0] cnt;
  logic            hit;

  assign hit     = run && (cnt == div);
  assign rise_ev = hit && !tck;
  assign fall_ev = hit && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end
endmodule

// File: rtl/jtag_chk_seq.sv
module jtag_chk_seq
  import jtag_chk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic chain_last,
  output logic run,
  output logic tms,
  output logic tdi,
  output logic shift_start,
  output logic sample,
  output logic fin_ev
);
  phase_e     phase;
  logic [2:0] rcnt;

  assign run         = (phase != PH_IDLE);
  assign shift_start = rise_ev && (phase == PH_CAP2);
  assign sample      = rise_ev && (phase == PH_SHIFT);
  assign fin_ev      = fall_ev && (phase == PH_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      rcnt  <= '0;
      tms   <= 1'b1;
      tdi   <= 1'b0;
    end else if (load) begin
      phase <= PH_RST;
      rcnt  <= '0;
      tms   <= 1'b1;
      tdi   <= 1'b0;
    end else if (rise_ev) begin
      case (phase)
        PH_RST:   if (rcnt == 3'(RESET_EDGES - 1)) phase <= PH_RTI;
                  else rcnt <= rcnt + 3'd1;
        PH_RTI:   phase <= PH_SDR;
        PH_SDR:   phase <= PH_SIR;
        PH_SIR:   phase <= PH_CAP;
        PH_CAP:   phase <= PH_CAP2;
        PH_CAP2:  phase <= PH_SHIFT;
        PH_SHIFT: if (chain_last) phase <= PH_UPD;
        PH_UPD:   phase <= PH_RTI2;
        PH_RTI2:  phase <= PH_FIN;
        default:  phase <= phase;
      endcase
    end else if (fall_ev) begin
      if (phase == PH_FIN) begin
        phase <= PH_IDLE;
      end else begin
        tms <= tms_for(phase, chain_last);
        tdi <= (phase == PH_SHIFT);
      end
    end
  end
endmodule

// File: rtl/jtag_chk_cmp.sv
module jtag_chk_cmp #(
  parameter int MAX_DEV = 4,
  parameter int MAX_IR  = 8,
  parameter int IDXW    = 3,
  parameter int IRLW    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [IDXW-1:0]           num_dev,
  input  logic [MAX_DEV*IRLW-1:0]   ir_len,
  input  logic [MAX_DEV*MAX_IR-1:0] exp_pat,
  input  logic                      shift_start,
  input  logic                      sample,
  input  logic                      tdo,
  output logic                      chain_last,
  output logic                      err,
  output logic [IDXW-1:0]           fidx
);
  localparam int DEVW = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1;
  localparam int BITW = (MAX_IR > 1) ? $clog2(MAX_IR) : 1;

  logic [MAX_IR-1:0] exp_q [MAX_DEV];
  logic [IRLW-1:0]   len_q [MAX_DEV];
  logic [IDXW-1:0]   num_q;
  logic [DEVW-1:0]   dev_p;
  logic [BITW-1:0]   bit_p;
  logic              last_in_dev;
  logic              exp_bit;

  assign exp_bit     = exp_q[dev_p][bit_p];
  assign last_in_dev = (IRLW'(bit_p) == len_q[dev_p] - IRLW'(1));
  assign chain_last  = last_in_dev && (IDXW'(dev_p) == num_q - IDXW'(1));

  // configuration store, no reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (load) begin
      for (int d = 0; d < MAX_DEV; d++) begin
        exp_q[d] <= exp_pat[d*MAX_IR +: MAX_IR];
        len_q[d] <= ir_len[d*IRLW +: IRLW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      dev_p <= '0;
      bit_p <= '0;
      err   <= 1'b0;
      fidx  <= '1;
    end else if (load) begin
      num_q <= num_dev;
      err   <= 1'b0;
      fidx  <= '1;
    end else if (shift_start) begin
      dev_p <= '0;
      bit_p <= '0;
    end else if (sample) begin
      if ((tdo != exp_bit) && !err) begin
        err  <= 1'b1;
        fidx <= IDXW'(dev_p);
      end
      if (last_in_dev) begin
        bit_p <= '0;
        if (!chain_last) dev_p <= dev_p + DEVW'(1);
      end else begin
        bit_p <= bit_p + BITW'(1);
      end
    end
  end
endmodule

// File: rtl/jtag_chain_check.sv
module jtag_chain_check #(
  parameter int MAX_DEV = 4,
  parameter int MAX_IR  = 8,
  parameter int DIVW    = 8,
  localparam int IDXW   = $clog2(MAX_DEV + 1),
  localparam int IRLW   = $clog2(MAX_IR + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [IDXW-1:0]           num_dev_i,
  input  logic [MAX_DEV*IRLW-1:0]   ir_len_i,
  input  logic [MAX_DEV*MAX_IR-1:0] exp_i,
  input  logic [DIVW-1:0]           div_i,
  input  logic                      tdo_i,
  output logic                      tck_o,
  output logic                      tms_o,
  output logic                      tdi_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      pass_o,
  output logic [IDXW-1:0]           fail_idx_o
);
  logic            load, run, rise_ev, fall_ev;
  logic            chain_last, shift_start, sample, fin_ev, err;
  logic [IDXW-1:0] fidx;
  logic [DIVW-1:0] div_q;

  assign load   = start_i && !run;
  assign busy_o = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      done_o     <= 1'b0;
      pass_o     <= 1'b0;
      fail_idx_o <= '1;
    end else begin
      done_o <= fin_ev;
      if (load) begin
        div_q      <= div_i;
        pass_o     <= 1'b0;
        fail_idx_o <= '1;
      end else if (fin_ev) begin
        pass_o     <= !err;
        fail_idx_o <= fidx;
      end
    end
  end

  jtag_chk_tck #(.DIVW(DIVW)) u_tck (
    .clk(clk), .rst(rst), .run(run), .div(div_q),
    .tck(tck_o), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  jtag_chk_seq u_seq (
    .clk(clk), .rst(rst), .load(load), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .chain_last(chain_last), .run(run), .tms(tms_o), .tdi(tdi_o),
    .shift_start(shift_start), .sample(sample), .fin_ev(fin_ev)
  );

  jtag_chk_cmp #(.MAX_DEV(MAX_DEV), .MAX_IR(MAX_IR), .IDXW(IDXW), .IRLW(IRLW)) u_cmp (
    .clk(clk), .rst(rst), .load(load), .num_dev(num_dev_i), .ir_len(ir_len_i),
    .exp_pat(exp_i), .shift_start(shift_start), .sample(sample), .tdo(tdo_i),
    .chain_last(chain_last), .err(err), .fidx(fidx)
  );
endmodule

// File: rtl/jtag_chain_check_sva.sv
module jtag_chain_check_sva #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            tck_o,
  input logic            tms_o,
  input logic            tdi_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            pass_o,
  input logic [IDXW-1:0] fail_idx_o
);
  logic       tck_d, busy_d, seen_low;
  logic [2:0] hi_cnt;
  logic       tck_rise;

  assign tck_rise = tck_o && !tck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_d    <= 1'b0;
      busy_d   <= 1'b0;
      hi_cnt   <= '0;
      seen_low <= 1'b0;
    end else begin
      tck_d  <= tck_o;
      busy_d <= busy_o;
      if (busy_o && !busy_d) begin
        hi_cnt   <= '0;
        seen_low <= 1'b0;
      end else if (tck_rise) begin
        if (tms_o && !seen_low && hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
        if (!tms_o) seen_low <= 1'b1;
      end
    end
  end

  AST_RESET_EDGES: assert property (@(posedge clk) disable iff (rst)
    (tck_rise && busy_o && !tms_o && !seen_low) |-> (hi_cnt == 3'd5)); // R1
  AST_TMS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tms_o) |-> ($fell(tck_o) || $rose(busy_o))); // R3
  AST_TDI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tdi_o) |-> ($fell(tck_o) || $rose(busy_o))); // R3
  AST_PASS_CODE: assert property (@(posedge clk) disable iff (rst)
    (done_o && pass_o) |-> (fail_idx_o == {IDXW{1'b1}})); // R8
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (rst)
    (done_o && !pass_o) |-> (fail_idx_o != {IDXW{1'b1}})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !tck_o)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o && !$rose(busy_o)) |-> ($stable(pass_o) && $stable(fail_idx_o))); // R10
endmodule

bind jtag_chain_check jtag_chain_check_sva #(.IDXW(IDXW)) u_sva (
  .clk(clk), .rst(rst), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o),
  .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_idx_o(fail_idx_o)
);

// File: tb/sim_jtag_chain_check.sv
module sim_jtag_chain_check;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_DEV = 4;
  localparam int MAX_IR  = 8;
  localparam int DIVW    = 8;
  localparam int IDXW    = 3;
  localparam int IRLW    = 4;

  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} ts_e;
  typedef struct {logic pass; logic [IDXW-1:0] idx; string tag;} res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [IDXW-1:0] num_dev_i = '0;
  logic [MAX_DEV*IRLW-1:0] ir_len_i = '0;
  logic [MAX_DEV*MAX_IR-1:0] exp_i = '0;
  logic [DIVW-1:0] div_i = '0;
  logic tdo_i = 1'b0;
  logic tck_o, tms_o, tdi_o, busy_o, done_o, pass_o;
  logic [IDXW-1:0] fail_idx_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int lens [MAX_DEV];
  logic [7:0] expv [MAX_DEV];
  logic [7:0] capv [MAX_DEV];
  logic [63:0] cap_vec = '0;
  int chain_len = 1;
  int cur_div = 0;
  res_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_chain_check u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .num_dev_i(num_dev_i),
    .ir_len_i(ir_len_i), .exp_i(exp_i), .div_i(div_i), .tdo_i(tdo_i),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .fail_idx_o(fail_idx_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expd);
    end
  endtask

  // behavioural target chain
  ts_e tst = SHDR;
  logic [63:0] chain = '0;
  logic [63:0] ir_upd = '0;
  int edge_total = 0, shift_total = 0, upd_total = 0;
  logic tms_hist [64];

  function automatic ts_e nxt(ts_e s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck_o) begin
    logic [63:0] nc;
    tms_hist[edge_total % 64] = tms_o;
    edge_total = edge_total + 1;
    if (tst == CIR) chain = cap_vec;
    if (tst == SHIR) begin
      nc = chain >> 1;
      nc[chain_len-1] = tdi_o;
      chain = nc;
      shift_total = shift_total + 1;
    end
    if (tst == UIR) begin
      ir_upd = chain;
      upd_total = upd_total + 1;
    end
    tst = nxt(tst, tms_o);
  end

  always @(negedge tck_o) tdo_i <= chain[0];

  // edge alignment and level length monitor (R3, R4)
  int bad_align = 0, bad_level = 0, seg_len = 0;
  bit seg_valid = 0;
  logic tck_p = 0, tms_p = 1, tdi_p = 0, busy_p = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if ((tms_o !== tms_p || tdi_o !== tdi_p) && !(tck_p && !tck_o) && !(busy_o && !busy_p))
        bad_align++;
      if (busy_o && !busy_p) begin
        seg_valid = 0;
        seg_len = 1;
      end else if (busy_o) begin
        if (tck_o != tck_p) begin
          if (seg_valid && seg_len != cur_div + 1) bad_level++;
          seg_valid = 1;
          seg_len = 1;
        end else seg_len++;
      end
    end
    tck_p = tck_o; tms_p = tms_o; tdi_p = tdi_o; busy_p = busy_o;
  end

  // scoreboard monitor (R8, R9, R12)
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb_q.size() == 0) begin
        chk(0, "R12 unexpected done", 1, 0);
      end else begin
        res_t e;
        e = sb_q.pop_front();
        chk(pass_o == e.pass, {e.tag, " pass"}, pass_o, e.pass);
        chk(fail_idx_o == e.idx, {e.tag, " fail index"}, fail_idx_o, e.idx);
      end
    end
  end

  task automatic run_case(input int n, input int dv, input bit ep, input int ei, input bit poke);
    int base_e, base_s, base_u, pos;
    logic [63:0] mask;
    logic exp_prefix [10] = '{1,1,1,1,1,0,1,1,0,0};
    bit pre_ok;
    res_t item;
    pos = 0;
    cap_vec = '0;
    for (int d = 0; d < MAX_DEV; d++) begin
      ir_len_i[d*IRLW +: IRLW] = IRLW'(lens[d]);
      exp_i[d*MAX_IR +: MAX_IR] = expv[d];
      if (d < n) begin
        for (int b = 0; b < lens[d]; b++) begin
          cap_vec[pos] = capv[d][b];
          pos++;
        end
      end
    end
    chain_len = pos;
    num_dev_i = IDXW'(n);
    div_i = DIVW'(dv);
    cur_div = dv;
    base_e = edge_total; base_s = shift_total; base_u = upd_total;
    item.pass = ep;
    item.idx = ep ? '1 : IDXW'(ei);
    item.tag = ep ? "R8/R7" : "R9/R7";
    sb_q.push_back(item);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      num_dev_i = 1;
      exp_i = ~exp_i;
      div_i = DIVW'(dv + 2);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk(!busy_o && !tck_o, "R10 idle at done", {busy_o, tck_o}, 0);
    pre_ok = 1;
    for (int k = 0; k < 10; k++) if (tms_hist[(base_e + k) % 64] !== exp_prefix[k]) pre_ok = 0;
    chk(pre_ok, "R1/R2 mode sequence", pre_ok, 1);
    chk(shift_total - base_s == chain_len, "R6 shift edges", shift_total - base_s, chain_len);
    chk(edge_total - base_e == chain_len + 12, "R6 total edges", edge_total - base_e, chain_len + 12);
    chk(upd_total - base_u == 1, "R6 update count", upd_total - base_u, 1);
    chk(tst == RTI, "R6 final state", tst, RTI);
    mask = (chain_len == 64) ? '1 : ((64'd1 << chain_len) - 64'd1);
    chk((ir_upd & mask) == mask, "R5 ones shifted in", ir_upd & mask, mask);
    chk(bad_align == 0, "R3 edge alignment", bad_align, 0);
    chk(bad_level == 0, "R4 level length", bad_level, 0);
    repeat (4) @(negedge clk);
    chk(pass_o == ep && done_o == 0, "R10 result held", pass_o, ep);
    if (poke) chk(sb_q.size() == 0, "R12 single run", sb_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !pass_o && !tck_o, "R11 reset outputs", {busy_o, done_o, pass_o, tck_o}, 0);
    chk(tms_o == 1'b1, "R11 reset mode line", tms_o, 1);
    chk(fail_idx_o == 3'd7, "R11 reset index", fail_idx_o, 7);

    // R7 R8: asymmetric patterns all match
    lens = '{4, 5, 2, 2}; expv = '{8'h0D, 8'h13, 8'h01, 8'h01};
    capv = expv;
    run_case(2, 1, 1, 0, 0);

    // R9: middle device wrong
    lens = '{3, 6, 2, 2}; expv = '{8'h05, 8'h21, 8'h01, 8'h01};
    capv = expv; capv[1] = 8'h23;
    run_case(3, 0, 0, 1, 0);

    // R9: two devices wrong, lowest reported
    lens = '{8, 8, 8, 8}; expv = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    capv = expv; capv[2] = 8'h01; capv[3] = 8'h7F;
    run_case(4, 2, 0, 2, 0);

    // R7 R9: single short device, bits swapped
    lens = '{2, 2, 2, 2}; expv = '{8'h01, 8'h01, 8'h01, 8'h01};
    capv = expv; capv[0] = 8'h02;
    run_case(1, 3, 0, 0, 0);

    // R12: restart attempt mid-run
    lens = '{2, 3, 4, 5}; expv = '{8'h01, 8'h05, 8'h09, 8'h11};
    capv = expv;
    run_case(4, 0, 1, 0, 1);

    // R6 R8: longest chain
    lens = '{8, 8, 8, 8}; expv = '{8'h35, 8'hC1, 8'h0F, 8'h99};
    capv = expv;
    run_case(4, 1, 1, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule